// File: doc/BRIEF.md
# Pipeline Interrupt Insertion Controller

This block steers the fetch stage of a three-stage (fetch, decode, execute) program controller when interrupts are serviced. Interrupt requests that are already synchronized to the clock are latched as pending. At the first legal fetch slot the controller replaces two normal fetches with two interrupt-vector fetches. It then tags each inserted word as it moves down the pipeline, so the execute stage knows which words are interrupt words.

If either vector word is a subroutine jump, the service becomes a long interrupt. The main program then stays suspended, and interrupts stay disabled, until a return-from-interrupt word reaches execute. A repeat instruction freezes fetching while its target repeats. No insertion may split a repeat from its target, and none may happen while the loop counter is above one. One clock equals one instruction cycle.

Top module: `irq_insert_ctrl`

## Requirements
- R1: Reset behaviour. While `rst` is high and in the first cycle after it, `fetch_sel` is 0 (program counter), `ins_stage` is 000 and `int_en` is 1. Reset also discards any pending request, so no vector fetch follows it without a new request.
- R2: A request pulse on `irq_req` becomes pending at the next edge. If the controller is running normally and the word fetched in that next cycle is not a repeat (`fetch_op` ≠ 1), the first vector fetch (`fetch_sel` = 1) takes place in the cycle after it.
- R3: Fast interrupt sequence. `fetch_sel` reads 1 and then 2 on consecutive cycles, with `int_en` low during both. If neither vector word was a jump, `fetch_sel` returns to 0 (resume main program) with `int_en` high in the following cycle.
- R4: `ins_stage` bit 0 flags an inserted word in fetch, bit 1 in decode and bit 2 in execute. An inserted word's flag reaches bit 2 exactly two cycles after it was set in bit 0.
- R5: Long interrupt. If `fetch_op` is 2 (jump) in either vector cycle, the controller fetches from the program counter (`fetch_sel` = 0) with `int_en` low until a word with `fetch_op` = 3 (return) is fetched. After that fetch it holds fetching (`fetch_sel` = 3) for two cycles while the return goes through decode and execute. It then resumes with `fetch_sel` = 0 and `int_en` high.
- R6: A request that arrives during a long interrupt stays pending and is serviced as soon as the long interrupt ends.
- R7: Repeat instruction. When a word with `fetch_op` = 1 (repeat) is fetched during normal running, the next cycle fetches the target (`fetch_sel` = 0). After that, `fetch_sel` stays 3 as long as `loop_count` ≠ 1. Normal fetching resumes the cycle after `loop_count` equals 1. No vector fetch happens anywhere in this span, and a request that arrives in it stays pending.
- R8: A repeat word fetched in the first cycle after a repeat ends blocks insertion again. Back-to-back repeats delay a pending interrupt until the last one has finished.
- R9: Requests on several lines at once are each serviced by a separate two-word vector sequence, back to back, with one program-counter fetch between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_IRQ | Synchronized interrupt request pulses, one per line |
| fetch_op | input | 2 | Class of the word fetched this cycle: 0 normal, 1 repeat, 2 jump to subroutine, 3 return from interrupt |
| loop_count | input | LC_W | Current loop counter value |
| fetch_sel | output | 2 | Fetch address source: 0 program counter, 1 vector word 0, 2 vector word 1, 3 hold (no fetch) |
| ins_stage | output | STAGES | Inserted-word flag per stage: bit 0 fetch, bit 1 decode, bit 2 execute |
| int_en | output | 1 | High when interrupts are enabled (not in service) |

## Verification
The main function is tried with four different patterns:
- A lone request during plain running. This shows the bare latency from request to first vector fetch and the fast return to the program counter.
- A jump in the first vector word, and separately a jump in the second. Together these show that either slot turns the service into a long interrupt, which ends only after a return plus two hold cycles.
- Requests that arrive during a long interrupt or during a repeat. These show that blocked requests are delayed rather than dropped.
- A repeat followed immediately by a second repeat, and two lines raised together. These separate the back-to-back blocking rule from simple one-shot blocking, and show that several pending lines get separate vector pairs.

Reset is applied in the middle of a long interrupt and with a request still pending, to show that both kinds of state are cleared.

// File: rtl/irq_insert_pkg.sv
package irq_insert_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN  = 2'd0,
        OP_REPEAT = 2'd1,
        OP_JUMP   = 2'd2,
        OP_RETURN = 2'd3
    } op_class_t;

    typedef enum logic [1:0] {
        SRC_PC   = 2'd0,
        SRC_VEC0 = 2'd1,
        SRC_VEC1 = 2'd2,
        SRC_HOLD = 2'd3
    } fetch_src_t;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_VEC0,
        ST_VEC1,
        ST_LONG,
        ST_REPT,
        ST_REPW,
        ST_RETD,
        ST_RETX
    } seq_state_t;

    typedef struct packed {
        fetch_src_t src;
        logic       inserted;
        logic       enabled;
    } fetch_ctl_t;

    function automatic fetch_ctl_t ctl_for(input seq_state_t s);
        fetch_ctl_t c;
        c.inserted = 1'b0;
        c.enabled  = 1'b0;
        c.src      = SRC_PC;
        case (s)
            ST_RUN:  c.enabled = 1'b1;
            ST_REPT: c.enabled = 1'b1;
            ST_REPW: begin c.enabled = 1'b1; c.src = SRC_HOLD; end
            ST_VEC0: begin c.src = SRC_VEC0; c.inserted = 1'b1; end
            ST_VEC1: begin c.src = SRC_VEC1; c.inserted = 1'b1; end
            ST_RETD: c.src = SRC_HOLD;
            ST_RETX: c.src = SRC_HOLD;
            default: c.src = SRC_PC;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] req,
    input  logic               take,
    output logic               any_pending
);
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] lowest;

    assign lowest      = pend_q & (~pend_q + 1'b1);
    assign any_pending = |pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~(take ? lowest : '0)) | req;
        end
    end

    // R6: a pending line not granted this cycle is still pending in the next
    assert_pending_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (any_pending && !take) |=> any_pending);

    // R2: a grant only happens when something is pending
    assert_take_needs_pending_R2: assert property (@(posedge clk) disable iff (rst)
        take |-> any_pending);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_insert_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pend_any,
    input  op_class_t  op,
    input  logic       lc_at_one,
    output fetch_ctl_t ctl,
    output logic       take
);
    seq_state_t state_q, state_d;
    logic       jump_seen_q, jump_seen_d;

    always_comb begin
        state_d     = state_q;
        jump_seen_d = jump_seen_q;
        take        = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (op == OP_REPEAT) begin
                    state_d = ST_REPT;
                end else if (pend_any) begin
                    state_d     = ST_VEC0;
                    take        = 1'b1;
                    jump_seen_d = 1'b0;
                end
            end
            ST_VEC0: begin
                state_d     = ST_VEC1;
                jump_seen_d = (op == OP_JUMP);
            end
            ST_VEC1: begin
                state_d     = (jump_seen_q || op == OP_JUMP) ? ST_LONG : ST_RUN;
                jump_seen_d = 1'b0;
            end
            ST_LONG: if (op == OP_RETURN) state_d = ST_RETD;
            ST_RETD: state_d = ST_RETX;
            ST_RETX: state_d = ST_RUN;
            ST_REPT: state_d = ST_REPW;
            ST_REPW: if (lc_at_one) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_RUN;
            jump_seen_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            jump_seen_q <= jump_seen_d;
        end
    end

    assign ctl = ctl_for(state_q);

    // R7: the repeat wait holds until the loop counter reaches one
    assert_rep_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REPW && !lc_at_one) |=> state_q == ST_REPW);

    // R5: once the return has been fetched, two hold cycles follow
    assert_ret_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RETD) |=> ctl.src == SRC_HOLD);
endmodule

// File: rtl/irq_tag_pipe.sv
module irq_tag_pipe #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tag_in,
    output logic [STAGES-1:0] tags
);
    assign tags[0] = tag_in;

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            logic tag_q;
            always_ff @(posedge clk) begin
                if (rst) tag_q <= 1'b0;
                else     tag_q <= tags[g-1];
            end
            assign tags[g] = tag_q;
        end
    endgenerate
endmodule

// File: rtl/irq_insert_ctrl.sv
module irq_insert_ctrl
    import irq_insert_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int LC_W    = 16,
    parameter int STAGES  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [1:0]         fetch_op,
    input  logic [LC_W-1:0]    loop_count,
    output logic [1:0]         fetch_sel,
    output logic [STAGES-1:0]  ins_stage,
    output logic               int_en
);
    localparam logic [LC_W-1:0] LC_ONE = LC_W'(1);

    logic       pend_any;
    logic       take;
    fetch_ctl_t ctl;
    op_class_t  op;

    assign op = op_class_t'(fetch_op);

    irq_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk         (clk),
        .rst         (rst),
        .req         (irq_req),
        .take        (take),
        .any_pending (pend_any)
    );

    irq_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .pend_any  (pend_any),
        .op        (op),
        .lc_at_one (loop_count == LC_ONE),
        .ctl       (ctl),
        .take      (take)
    );

    irq_tag_pipe #(.STAGES(STAGES)) u_tags (
        .clk    (clk),
        .rst    (rst),
        .tag_in (ctl.inserted),
        .tags   (ins_stage)
    );

    assign fetch_sel = ctl.src;
    assign int_en    = ctl.enabled;

    // R3: the first vector fetch is always followed by the second
    assert_vec_order_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_sel == SRC_VEC0) |=> (fetch_sel == SRC_VEC1));

    // R3: interrupts are disabled while vector words are fetched
    assert_vec_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_sel == SRC_VEC0 || fetch_sel == SRC_VEC1) |-> !int_en);

    // R4: a word flagged in execute was fetched from a vector two cycles earlier
    assert_exec_lag_R4: assert property (@(posedge clk) disable iff (rst)
        ins_stage[STAGES-1] |-> ($past(fetch_sel, 2) == SRC_VEC0 ||
                                 $past(fetch_sel, 2) == SRC_VEC1));

    // R6: no insertion directly out of a long interrupt
    assert_long_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (fetch_sel == SRC_PC && !int_en) |=> fetch_sel != SRC_VEC0);

    // R7: no insertion directly out of a repeat wait
    assert_rep_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (fetch_sel == SRC_HOLD && int_en) |=> fetch_sel != SRC_VEC0);
endmodule

// File: tb/irq_insert_ctrl_test.sv
`timescale 1ns/1ps
module irq_insert_ctrl_test;

    localparam logic [1:0] ON = 2'd0, OR = 2'd1, OJ = 2'd2, OT = 2'd3;
    localparam logic [1:0] PC = 2'd0, V0 = 2'd1, V1 = 2'd2, HD = 2'd3;
    localparam int NSTEP = 54;

    // {irq[13:12], op[11:10], lc[9:6], sel[5:4], ins[3:1], en[0]}
    localparam logic [13:0] TBL [0:NSTEP-1] = '{
        {2'd0,ON,4'd0,PC,3'b000,1'b1}, {2'd1,ON,4'd0,PC,3'b000,1'b1},
        {2'd0,ON,4'd0,PC,3'b000,1'b1}, {2'd0,ON,4'd0,V0,3'b001,1'b0},
        {2'd0,ON,4'd0,V1,3'b011,1'b0}, {2'd0,ON,4'd0,PC,3'b110,1'b1},
        {2'd0,ON,4'd0,PC,3'b100,1'b1}, {2'd0,ON,4'd0,PC,3'b000,1'b1},
        {2'd1,ON,4'd0,PC,3'b000,1'b1}, {2'd0,ON,4'd0,PC,3'b000,1'b1},
        {2'd0,OJ,4'd0,V0,3'b001,1'b0}, {2'd0,ON,4'd0,V1,3'b011,1'b0},
        {2'd2,ON,4'd0,PC,3'b110,1'b0}, {2'd0,ON,4'd0,PC,3'b100,1'b0},
        {2'd0,OT,4'd0,PC,3'b000,1'b0}, {2'd0,ON,4'd0,HD,3'b000,1'b0},
        {2'd0,ON,4'd0,HD,3'b000,1'b0}, {2'd0,ON,4'd0,PC,3'b000,1'b1},
        {2'd0,ON,4'd0,V0,3'b001,1'b0}, {2'd0,ON,4'd0,V1,3'b011,1'b0},
        {2'd0,ON,4'd0,PC,3'b110,1'b1}, {2'd0,ON,4'd0,PC,3'b100,1'b1},
        {2'd0,ON,4'd0,PC,3'b000,1'b1}, {2'd1,OR,4'd3,PC,3'b000,1'b1},
        {2'd0,ON,4'd3,PC,3'b000,1'b1}, {2'd0,ON,4'd3,HD,3'b000,1'b1},
        {2'd0,ON,4'd2,HD,3'b000,1'b1}, {2'd0,ON,4'd1,HD,3'b000,1'b1},
        {2'd0,ON,4'd1,PC,3'b000,1'b1}, {2'd0,ON,4'd1,V0,3'b001,1'b0},
        {2'd0,ON,4'd1,V1,3'b011,1'b0}, {2'd0,ON,4'd1,PC,3'b110,1'b1},
        {2'd0,ON,4'd1,PC,3'b100,1'b1}, {2'd0,ON,4'd1,PC,3'b000,1'b1},
        {2'd1,OR,4'd2,PC,3'b000,1'b1}, {2'd0,ON,4'd2,PC,3'b000,1'b1},
        {2'd0,ON,4'd1,HD,3'b000,1'b1}, {2'd0,OR,4'd2,PC,3'b000,1'b1},
        {2'd0,ON,4'd2,PC,3'b000,1'b1}, {2'd0,ON,4'd1,HD,3'b000,1'b1},
        {2'd0,ON,4'd1,PC,3'b000,1'b1}, {2'd0,ON,4'd1,V0,3'b001,1'b0},
        {2'd0,ON,4'd1,V1,3'b011,1'b0}, {2'd0,ON,4'd1,PC,3'b110,1'b1},
        {2'd0,ON,4'd1,PC,3'b100,1'b1}, {2'd1,ON,4'd0,PC,3'b000,1'b1},
        {2'd0,ON,4'd0,PC,3'b000,1'b1}, {2'd0,ON,4'd0,V0,3'b001,1'b0},
        {2'd0,OJ,4'd0,V1,3'b011,1'b0}, {2'd0,ON,4'd0,PC,3'b110,1'b0},
        {2'd0,OT,4'd0,PC,3'b100,1'b0}, {2'd0,ON,4'd0,HD,3'b000,1'b0},
        {2'd0,ON,4'd0,HD,3'b000,1'b0}, {2'd0,ON,4'd0,PC,3'b000,1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  irq_req = '0;
    logic [1:0]  fetch_op = '0;
    logic [15:0] loop_count = '0;
    logic [1:0]  fetch_sel;
    logic [2:0]  ins_stage;
    logic        int_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_insert_ctrl uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .fetch_op(fetch_op),
        .loop_count(loop_count), .fetch_sel(fetch_sel),
        .ins_stage(ins_stage), .int_en(int_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string step_tag(input int i);
        if (i <= 2)  return "R2";
        if (i <= 7)  return "R3";
        if (i <= 16) return "R5";
        if (i <= 22) return "R6";
        if (i <= 33) return "R7";
        if (i <= 44) return "R8";
        return "R5";
    endfunction

    task automatic step(input logic [3:0] irq, input logic [1:0] op);
        @(negedge clk);
        irq_req  = irq;
        fetch_op = op;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; irq_req = '0; fetch_op = ON;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R1 sel in reset", fetch_sel, PC);
        check("R1 ins in reset", ins_stage, 0);
        check("R1 en in reset", int_en, 1);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();

        // table walk: one entry per instruction cycle
        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            irq_req    = {2'b00, TBL[i][13:12]};
            fetch_op   = TBL[i][11:10];
            loop_count = {12'd0, TBL[i][9:6]};
            #1;
            check(step_tag(i), fetch_sel, TBL[i][5:4]);
            check("R4", ins_stage, TBL[i][3:1]);
            check(step_tag(i), int_en, TBL[i][0]);
        end

        // R9: two lines raised together give two vector pairs
        step(4'b0011, ON); check("R9 idle", fetch_sel, PC);
        step(4'b0000, ON); check("R9 decide", fetch_sel, PC);
        step(4'b0000, ON); check("R9 first v0", fetch_sel, V0);
        step(4'b0000, ON); check("R9 first v1", fetch_sel, V1);
        step(4'b0000, ON); check("R3 resume pc", fetch_sel, PC);
        check("R3 resume en", int_en, 1);
        step(4'b0000, ON); check("R9 second v0", fetch_sel, V0);
        step(4'b0000, ON); check("R9 second v1", fetch_sel, V1);
        step(4'b0000, ON); check("R9 after", fetch_sel, PC);
        step(4'b0000, ON); check("R9 nothing left", fetch_sel, PC);
        step(4'b0000, ON); check("R9 nothing left", fetch_sel, PC);

        // R1: reset in the middle of a long interrupt
        step(4'b0001, ON);
        step(4'b0000, ON);
        step(4'b0000, OJ); check("R5 v0", fetch_sel, V0);
        step(4'b0000, ON);
        step(4'b0000, ON); check("R5 long en", int_en, 0);
        do_reset();
        step(4'b0000, ON); check("R1 en after reset", int_en, 1);
        check("R1 ins after reset", ins_stage, 0);

        // R1: reset discards a pending request
        step(4'b0100, ON);
        do_reset();
        for (int k = 0; k < 4; k++) begin
            step(4'b0000, ON);
            check("R1 no stale service", fetch_sel, PC);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule